// File: doc/BRIEF.md
# Gated Raw-Sample Register Block

This block holds the latest raw 12-bit conversion result for each of a small number of converter channels and makes them readable over a simple register bus. A result register follows its incoming sample stream only while every prerequisite for that channel holds. The prerequisites are a port clock enable, a converter interface clock enable, the channel's pad-configuration nibble set to analog input (all zero), and the channel's enable bit in the control register. Both clock enables are bits of a sampled clock-enable word.

If any prerequisite is missing, the result register is forced to zero instead of keeping a stale or invented value. A per-channel gated output shows the missing route at once, so a consumer can tell a closed path from a genuine zero reading. Software opens a route by writing the control register and then polls the matching result offset.

Top module: `adc_gate_regs`

## Requirements
- R1: After the asynchronous active-low reset the control register, every result register and the read-data output are all zero.
- R2: Offset 0x00 is the control register. Bit c enables channel c (bits 1:0 for two channels). A write stores those bits, and a read returns them with every other bit zero.
- R3: The result of channel c is read at offset 4*(c+1), giving 0x04 for channel 0 and 0x08 for channel 1, with the sample in bits 11:0 and bits 31:12 zero.
- R4: Channel c is open only when bit 2 and bit 9 of the clock-enable word are 1, pad-configuration bits [4c+3:4c] equal 0x0, and control bit c is 1. gated_o[c] is the combinational inverse of that condition.
- R5: While channel c is open, a cycle with smp_valid_i[c] high loads smp_data_i[12c+11:12c] into its result at that clock edge. Cycles without valid leave the result unchanged.
- R6: At the first clock edge where channel c is not open, its result becomes 0. It stays 0 while the channel is gated, whatever the samples on its stream, including when its pad nibble selects a digital output mode.
- R7: Writes to the result offsets and to unmapped offsets change no register. A read of an unmapped offset returns 0.
- R8: Read data appears on bus_rdata_o one clock after a cycle with bus_rd_i high. After a cycle without a read, bus_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| clk_en_word_i | input | 32 | Sampled clock-enable word (bit 2 port, bit 9 converter) |
| pad_cfg_word_i | input | 32 | Sampled pad configuration, one nibble per channel |
| smp_valid_i | input | 2 | Per-channel sample strobe |
| smp_data_i | input | 24 | Per-channel 12-bit samples, channel c in [12c+11:12c] |
| gated_o | output | 2 | Per-channel route-closed indicator |

## Verification
A closed route that still loads samples shows up as a nonzero result read at the channel offset within two clocks of the sample strobe. A wrong control-register bit shows up at once on gated_o and in the read-back of offset 0x00. Each prerequisite is dropped on its own, so a missing term in the open condition shows on gated_o in the same cycle and as a stale nonzero read one read later. Writes to read-only and unmapped offsets are each followed by read-back of every register, so a decode that leaks shows up as a changed control value.

// File: rtl/adc_gate_pkg.sv
package adc_gate_pkg;
  localparam int unsigned PORT_CLK_BIT = 2;
  localparam int unsigned CONV_CLK_BIT = 9;
  localparam int unsigned NIB_W        = 4;
  localparam int unsigned REG_STRIDE   = 4;
endpackage

// File: rtl/adc_gate_path.sv
module adc_gate_path
  import adc_gate_pkg::*;
#(
  parameter int unsigned CH   = 0,
  parameter int unsigned CE_W = 32,
  parameter int unsigned PC_W = 32
) (
  input  logic [CE_W-1:0] clk_en_word_i,
  input  logic [PC_W-1:0] pad_cfg_word_i,
  input  logic            ch_en_i,
  output logic            open_o
);
  localparam int unsigned NIB_LO = CH * NIB_W;

  logic analog_mode;
  assign analog_mode = (pad_cfg_word_i[NIB_LO +: NIB_W] == '0);
  assign open_o = clk_en_word_i[PORT_CLK_BIT] & clk_en_word_i[CONV_CLK_BIT]
                & analog_mode & ch_en_i;
endmodule

// File: rtl/adc_gate_result.sv
module adc_gate_result #(
  parameter int unsigned SMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] data_i,
  output logic [SMP_W-1:0] res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_o <= '0;
    else if (!open_i) res_o <= '0;
    else if (valid_i) res_o <= data_i;
  end
endmodule

// File: rtl/adc_gate_ctrl.sv
module adc_gate_ctrl #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic           bus_wr_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [NCH-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ctrl_o <= '0;
    else if (bus_wr_i && bus_addr_i == '0)  ctrl_o <= bus_wdata_i[NCH-1:0];
  end
endmodule

// File: rtl/adc_gate_regs.sv
module adc_gate_regs
  import adc_gate_pkg::*;
#(
  parameter int unsigned NCH   = 2,
  parameter int unsigned SMP_W = 12,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned CE_W  = 32,
  parameter int unsigned PC_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [CE_W-1:0]    clk_en_word_i,
  input  logic [PC_W-1:0]    pad_cfg_word_i,
  input  logic [NCH-1:0]     smp_valid_i,
  input  logic [NCH*SMP_W-1:0] smp_data_i,
  output logic [NCH-1:0]     gated_o
);
  logic [NCH-1:0]       ctrl_q;
  logic [NCH-1:0]       open_w;
  logic [NCH*SMP_W-1:0] res_flat;
  logic [DW-1:0]        rd_val;

  adc_gate_ctrl #(.NCH(NCH), .AW(AW), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_wdata_i, .ctrl_o(ctrl_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    adc_gate_path #(.CH(c), .CE_W(CE_W), .PC_W(PC_W)) u_path (
      .clk_en_word_i, .pad_cfg_word_i, .ch_en_i(ctrl_q[c]), .open_o(open_w[c])
    );
    adc_gate_result #(.SMP_W(SMP_W)) u_res (
      .clk_i, .rst_ni,
      .open_i (open_w[c]),
      .valid_i(smp_valid_i[c]),
      .data_i (smp_data_i[c*SMP_W +: SMP_W]),
      .res_o  (res_flat[c*SMP_W +: SMP_W])
    );
  end

  assign gated_o = ~open_w;

  always_comb begin
    rd_val = '0;
    if (bus_addr_i == '0) rd_val = DW'(ctrl_q);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr_i == AW'((c + 1) * REG_STRIDE))
        rd_val = DW'(res_flat[c*SMP_W +: SMP_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_val;
    else               bus_rdata_o <= '0;
  end
endmodule

// File: rtl/adc_gate_chk.sv
module adc_gate_chk #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned SMP_W = 12,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned CE_W  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [AW-1:0]        bus_addr_i,
  input logic                 bus_wr_i,
  input logic                 bus_rd_i,
  input logic [DW-1:0]        bus_wdata_i,
  input logic [DW-1:0]        bus_rdata_o,
  input logic [CE_W-1:0]      clk_en_word_i,
  input logic [NCH-1:0]       smp_valid_i,
  input logic [NCH*SMP_W-1:0] smp_data_i,
  input logic [NCH-1:0]       gated_o,
  input logic [NCH-1:0]       ctrl_q,
  input logic [NCH*SMP_W-1:0] res_flat
);
  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == '0) |=> ctrl_q == $past(bus_wdata_i[NCH-1:0]));
  // R7
  ro_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != '0) |=> $stable(ctrl_q));
  // R4
  clk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clk_en_word_i[2] && clk_en_word_i[9]) |-> (&gated_o));
  // R5
  cap1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gated_o[1] && smp_valid_i[1]) |=> res_flat[SMP_W +: SMP_W] == $past(smp_data_i[SMP_W +: SMP_W]));
  // R6
  drop1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_o[1] |=> res_flat[SMP_W +: SMP_W] == '0);
  // R6
  drop0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_o[0] |=> res_flat[SMP_W-1:0] == '0);
  // R8
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == '0);
  // R3
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DW-1:SMP_W] == '0);
endmodule

bind adc_gate_regs adc_gate_chk #(
  .NCH(NCH), .SMP_W(SMP_W), .AW(AW), .DW(DW), .CE_W(CE_W)
) u_chk (
  .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_rd_i, .bus_wdata_i,
  .bus_rdata_o, .clk_en_word_i, .smp_valid_i, .smp_data_i, .gated_o,
  .ctrl_q, .res_flat
);

// File: tb/sim_adc_gate_regs.sv
module sim_adc_gate_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [31:0] clk_en_word_i = '0;
  logic [31:0] pad_cfg_word_i = '0;
  logic [1:0]  smp_valid_i = '0;
  logic [23:0] smp_data_i = '0;
  logic [1:0]  gated_o;

  int vectors = 0;
  int miscompares = 0;

  localparam logic [31:0] CE_ALL = 32'h0000_0204;

  always #2.5 clk_i = ~clk_i;

  adc_gate_regs u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk_i);
    d = bus_rdata_o;
    bus_rd_i = 1'b0;
  endtask

  task automatic push(int ch, logic [11:0] v);
    @(negedge clk_i);
    smp_data_i[ch*12 +: 12] = v; smp_valid_i[ch] = 1'b1;
    @(negedge clk_i);
    smp_valid_i[ch] = 1'b0;
  endtask

  task automatic open_all();
    clk_en_word_i = CE_ALL; pad_cfg_word_i = '0;
    bus_write(8'h00, 32'h3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rdata", bus_rdata_o, 0);
    check("R1 gated", 32'(gated_o), 32'h3);
    bus_read(8'h00, d); check("R1 ctrl", d, 0);
    bus_read(8'h04, d); check("R1 res0", d, 0);
    bus_read(8'h08, d); check("R1 res1", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bus_write(8'h00, 32'hFFFF_FFFE);
    bus_read(8'h00, d); check("R2 ctrl reserved", d, 32'h2);
    bus_write(8'h00, 32'h1);
    bus_read(8'h00, d); check("R2 ctrl ch0", d, 32'h1);
    @(negedge clk_i);
    check("R8 idle rdata", bus_rdata_o, 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    open_all();
    #1 check("R4 open", 32'(gated_o), 0);
    push(1, 12'hABC);
    bus_read(8'h08, d); check("R5 ch1 capture", d, 32'hABC);
    push(1, 12'hFFF);
    bus_read(8'h08, d); check("R3 ch1 full", d, 32'hFFF);
    repeat (3) @(negedge clk_i);
    bus_read(8'h08, d); check("R5 ch1 hold", d, 32'hFFF);
    push(0, 12'h123);
    bus_read(8'h04, d); check("R3 ch0 offset", d, 32'h123);
    bus_read(8'h08, d); check("R5 ch1 unaffected", d, 32'hFFF);
  endtask

  task automatic t_prereq();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      open_all();
      push(1, 12'h5A5);
      @(negedge clk_i);
      case (k)
        0: clk_en_word_i[2] = 1'b0;
        1: clk_en_word_i[9] = 1'b0;
        2: pad_cfg_word_i[7:4] = 4'h1;
        default: ;
      endcase
      if (k == 3) bus_write(8'h00, 32'h1);
      #1 check("R4 gated ch1", 32'(gated_o[1]), 1);
      push(1, 12'h777);
      bus_read(8'h08, d); check("R6 ch1 zero", d, 0);
    end
  endtask

  task automatic t_pad_out();
    logic [31:0] d;
    open_all();
    push(0, 12'h0F0);
    @(negedge clk_i);
    pad_cfg_word_i[3:0] = 4'h3;
    #1 check("R4 pad out gated", 32'(gated_o), 32'h1);
    push(0, 12'h333);
    bus_read(8'h04, d); check("R6 pad out ch0", d, 0);
    pad_cfg_word_i = '0;
    push(0, 12'h444);
    bus_read(8'h04, d); check("R5 reopen ch0", d, 32'h444);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    open_all();
    push(1, 12'h246);
    bus_write(8'h08, 32'h0);
    bus_write(8'h04, 32'h0);
    bus_write(8'h0C, 32'h0);
    bus_write(8'h40, 32'h0);
    bus_read(8'h00, d); check("R7 ctrl kept", d, 32'h3);
    bus_read(8'h08, d); check("R7 res1 kept", d, 32'h246);
    bus_read(8'h0C, d); check("R7 unmapped", d, 0);
    bus_read(8'h02, d); check("R7 unaligned", d, 0);
  endtask

  initial begin
    #1_000_000;
    miscompares++; vectors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ctrl();
    t_capture();
    t_prereq();
    t_pad_out();
    t_ro();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule